// File: doc/BRIEF.md
# Invert-and-Select Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit for a simple processor datapath. Each result bit comes from a small slice that can complement either operand, then picks one of four candidate values: the bitwise AND, the bitwise OR, the full-adder sum, or a "less" input. The slices are chained through a ripple carry, and the carry into the lowest slice is tied to the operand-B complement control. As a result, subtraction and comparison use the same adder as addition.

A 4-bit operation code drives the slices directly. Bit 3 complements A, bit 2 complements B and also sets the carry-in, and bits 1:0 select the candidate (00 AND, 01 OR, 10 sum, 11 less). The less candidate is the sign of the adder output, routed to bit 0 only. A zero flag reports an all-zero result, which a branch-on-equal decision can use after a subtraction. The unit has no clock and no storage. A decoder upstream supplies the code, and the outputs settle within the same cycle.

Top module: `invsel_alu`

## Requirements
- R1: Code 0000 gives `res = a & b`.
- R2: Code 0001 gives `res = a | b`.
- R3: Code 0010 gives `res = a + b` modulo 2^32, with any carry out of bit 31 discarded.
- R4: Code 0110 gives `res = a - b` modulo 2^32, formed as `a + ~b + 1`.
- R5: Code 0111 gives a result whose bit 0 equals bit 31 of `a - b`, with bits 31:1 all zero.
- R6: Code bit 3 complements A and code bit 2 complements B before the selected operation, and the adder carry-in equals code bit 2. This holds for all 16 codes, for example code 1010 gives `~a + b`.
- R7: `zero` is 1 exactly when `res` is all zeros.
- R8: Code 1100 gives `res = ~(a | b)`, the NOR of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctl | input | 4 | Operation code: [3] complement A, [2] complement B and carry-in, [1:0] candidate select |
| res | output | 32 | Result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The corner cases are chosen to expose specific mistakes:
- A carry chain that breaks or starts from the wrong carry-in shows up as off-by-one errors in subtraction, or as failures on long carry propagation such as 0xFFFFFFFF + 1.
- A less path routed to the wrong bit, or a set of upper result bits left undriven, shows up when comparing the most negative and most positive values. Those two values also reveal whether the comparison uses the raw sign of the difference.
- Equal operands under subtraction test the zero flag, and so does a result whose only set bit is bit 31.
- Every one of the 16 codes, including the unnamed ones, is compared against an independent model of the invert-then-select rule. This catches a swapped complement control or swapped select encodings.

// File: rtl/invsel_alu_pkg.sv
// Package: shared definitions for the invert-and-select ALU.
// Assumes the code layout {a_inv, b_inv, sel[1:0]}; sel picks the per-bit candidate.
package invsel_alu_pkg;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } bit_sel_e;

    typedef struct packed {
        logic     a_inv;
        logic     b_inv;
        bit_sel_e sel;
    } alu_code_t;
endpackage

// File: rtl/invsel_slice.sv
// Module: one bit of the ALU. Optionally complements each operand bit,
// forms the full-adder sum and carry, then selects AND, OR, sum or the
// externally supplied less bit. Assumes the caller builds the carry chain.
module invsel_slice
    import invsel_alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     a_inv,
    input  logic     b_inv,
    input  logic     cin,
    input  logic     less_i,
    input  bit_sel_e sel,
    output logic     res_o,
    output logic     sum_o,
    output logic     cout
);
    logic a_eff;
    logic b_eff;

    // Purpose: operand conditioning and full adder.
    always_comb begin
        a_eff = a_inv ? ~a_i : a_i;
        b_eff = b_inv ? ~b_i : b_i;
        sum_o = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
    end

    // Purpose: pick the candidate named by the select field.
    always_comb begin
        unique case (sel)
            SEL_AND:  res_o = a_eff & b_eff;
            SEL_OR:   res_o = a_eff | b_eff;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/invsel_zero_det.sv
// Module: reports whether a vector is all zeros. Assumes WIDTH >= 1.
module invsel_zero_det #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             is_zero
);
    // Purpose: NOR-reduce the vector.
    always_comb is_zero = ~|vec;
endmodule

// File: rtl/invsel_alu.sv
// Module: top of the ALU. Replicates one slice per bit, ripples the carry
// from a carry-in equal to the B-complement control, feeds the sign of the
// top sum back into bit 0 as the less candidate, and flags a zero result.
// Assumes a purely combinational context; no clock or reset is used.
module invsel_alu
    import invsel_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic [CODE_W-1:0] ctl,
    output logic [WIDTH-1:0]  res,
    output logic              zero
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_code_t        code;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_bits;
    logic             sign_of_sum;

    // Purpose: unpack the code and seed the carry chain.
    always_comb begin
        code     = alu_code_t'(ctl);
        carry[0] = code.b_inv;
    end

    assign sign_of_sum = sum_bits[MSB];

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_slice
            logic less_in;
            if (i == 0) begin : g_low
                assign less_in = sign_of_sum;
            end else begin : g_rest
                assign less_in = 1'b0;
            end
            invsel_slice u_slice (
                .a_i    (a[i]),
                .b_i    (b[i]),
                .a_inv  (code.a_inv),
                .b_inv  (code.b_inv),
                .cin    (carry[i]),
                .less_i (less_in),
                .sel    (code.sel),
                .res_o  (res[i]),
                .sum_o  (sum_bits[i]),
                .cout   (carry[i+1])
            );
        end
    endgenerate

    invsel_zero_det #(.WIDTH(WIDTH)) u_zero (
        .vec     (res),
        .is_zero (zero)
    );
endmodule

// File: rtl/invsel_alu_chk.sv
// Checker: immediate assertions on the ALU ports, attached by bind.
// Assumes inputs are known; checks are skipped while any input is X.
module invsel_alu_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       ctl,
    input logic [WIDTH-1:0] res,
    input logic             zero
);
    logic [WIDTH-1:0] diff;
    assign diff = a - b;

    // Purpose: port-level consistency checks per requirement.
    always_comb begin
        if (!$isunknown({a, b, ctl})) begin
            if (ctl == 4'b0000) a_r1_and: assert (res == (a & b));
            if (ctl == 4'b0001) a_r2_or: assert (res == (a | b));
            if (ctl == 4'b0110) a_r4_sub: assert (res == diff);
            if (ctl == 4'b0111) a_r5_slt: assert (res == {{(WIDTH-1){1'b0}}, diff[WIDTH-1]});
            if (ctl == 4'b1100) a_r8_nor: assert (res == ~(a | b));
            a_r7_zero: assert (zero == (res == '0));
        end
    end
endmodule

bind invsel_alu invsel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a    (a),
    .b    (b),
    .ctl  (ctl),
    .res  (res),
    .zero (zero)
);

// File: tb/invsel_alu_test.sv
module invsel_alu_test;
    logic        clk = 1'b0;
    logic [31:0] a, b, res;
    logic [3:0]  ctl;
    logic        zero;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    invsel_alu uut (.a(a), .b(b), .ctl(ctl), .res(res), .zero(zero));

    // Independent model: complement, carry-in from bit 2, then select.
    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [3:0] c);
        logic [31:0] xe, ye, s;
        xe = c[3] ? ~x : x;
        ye = c[2] ? ~y : y;
        s  = xe + ye + {31'd0, c[2]};
        case (c[1:0])
            2'b00:   return xe & ye;
            2'b01:   return xe | ye;
            2'b10:   return s;
            default: return {31'd0, s[31]};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check_res(input string tag, input logic [31:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h ctl=%b res=%h expected=%h", tag, a, b, ctl, res, exp);
        end
    endtask

    task automatic check_zero(input logic exp);
        checks++;
        if (zero !== exp) begin
            fails++;
            $display("FAIL R7 a=%h b=%h ctl=%b zero=%b expected=%b", a, b, ctl, zero, exp);
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
        logic [31:0] e;
        @(negedge clk);
        a = x; b = y; ctl = c;
        #1;
        e = model(x, y, c);
        check_res(tag_of(c), e);
        check_zero(e == 32'd0);
    endtask

    initial begin
        a = '0; b = '0; ctl = '0;
        #1;
        // Initial state: zero operands with AND.
        check_res("R1", 32'd0);
        check_zero(1'b1);
        // Directed corners.
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000);          // R1
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001);          // R2
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);          // R3 full carry ripple, wraps to 0
        apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);          // R3
        apply(32'h0000_0005, 32'h0000_0005, 4'b0110);          // R4 and R7: equal operands give zero
        apply(32'h0000_0000, 32'h0000_0001, 4'b0110);          // R4 borrow gives all ones
        apply(32'h0000_0003, 32'h0000_0007, 4'b0111);          // R5 less: result 1
        apply(32'h0000_0007, 32'h0000_0003, 4'b0111);          // R5 not less: result 0
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);          // R5 sign of wrapped difference
        apply(32'h8000_0000, 32'h0000_0000, 4'b0010);          // R7 only bit 31 set, zero must be 0
        apply(32'h1234_5678, 32'h0F0F_0F0F, 4'b1100);          // R8 NOR
        apply(32'h0000_0000, 32'h0000_0000, 4'b1100);          // R8 all ones
        apply(32'h0000_0010, 32'h0000_0003, 4'b1010);          // R6 ~a + b
        apply(32'hAAAA_5555, 32'hFFFF_0000, 4'b0100);          // R6 a & ~b
        // Constrained random over all codes with a fixed seed.
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = (i % 7 == 0) ? x : $urandom();
            if (i % 11 == 0) x = {x[31], 31'd0};
            apply(x, y, 4'(i % 16));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule